// File: doc/BRIEF.md
# Saturating Bias Position Combiner

This block sets the wiper code of two 256-position bias potentiometers. At each conversion round it fetches, for every channel, an unsigned base position from that channel's temperature table and a signed offset from that channel's drain table. It fetches them through one shared synchronous read port, adds the pair, limits the result to the code range 0..255 and registers both wiper codes at once.

The temperature index is shared by both channels. Each channel has its own drain index. The indexes come either from the monitor inputs or, in manual mode, from manually written index inputs. A freeze input stops all automatic updating. While it is set, a round request starts no reads and both wipers keep their codes.

Top module: `bias_combiner`

## Requirements
- R1: While reset is high and in the cycle after it, both wiper outputs read 0, and `rd_en` and `upd_done` are low.
- R2: When the sum lies in 0..255, a channel's wiper equals its unsigned base byte plus its drain byte taken as two's complement.
- R3: A sum above 255 (up to 382) gives wiper code 255. A sum of exactly 255 gives 255.
- R4: A sum below 0 (down to -128) gives wiper code 0.
- R5: Channel 0 takes its base from table select 0 and its offset from table select 2. Channel 1 takes its base from select 1 and its offset from select 3. Base reads use the temperature index as address. Offset reads use that channel's drain index.
- R6: An accepted round makes exactly four reads, one per cycle, in the four cycles after the accepting edge, in select order 0, 2, 1, 3. Read data is taken one cycle after its request.
- R7: Both wipers change only at the sixth rising edge after the accepting edge, where `upd_done` goes high for that one cycle. At all other times the wipers hold.
- R8: With `freeze_en` high, `round_start` is ignored. No read is issued and both wipers keep their codes.
- R9: With `manual_en` high at the accepting edge, the round uses `man_tidx`, `man_didx0` and `man_didx1`, and the monitor indexes have no effect.
- R10: A `round_start` that arrives while a round is in progress, up to and including its update edge, is ignored.
- R11: Indexes are captured at the accepting edge. Later index changes do not affect that round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| round_start | input | 1 | One-cycle request: a conversion round has ended |
| freeze_en | input | 1 | Stops automatic updating |
| manual_en | input | 1 | Selects the manual indexes |
| mon_tidx | input | TIDX_W (7) | Temperature index from the monitor |
| mon_didx0 | input | DIDX_W (6) | Channel 0 drain index from the monitor |
| mon_didx1 | input | DIDX_W (6) | Channel 1 drain index from the monitor |
| man_tidx | input | TIDX_W (7) | Manual temperature index |
| man_didx0 | input | DIDX_W (6) | Manual channel 0 drain index |
| man_didx1 | input | DIDX_W (6) | Manual channel 1 drain index |
| rd_en | output | 1 | Table read request |
| rd_sel | output | 2 | Table select: 0/1 base ch0/ch1, 2/3 offset ch0/ch1 |
| rd_addr | output | ADDR_W (7) | Table entry address |
| rd_data | input | 8 | Read data, valid one cycle after the request |
| wiper0 | output | 8 | Channel 0 wiper code |
| wiper1 | output | 8 | Channel 1 wiper code |
| upd_done | output | 1 | High for one cycle after the wipers are loaded |

## Verification
Counting from the rising edge that accepts `round_start`, read k (k = 0..3) must be on the port in the cycle after edge k. Its data returns after edge k+1 and is taken at edge k+2. The wipers and `upd_done` are due right after edge 6. A behavioural model in the bench follows the same edge count and compares the read port, both wipers and `upd_done` at every falling edge, so an early or late result is a mismatch. The directed cases for clamping, channel mapping, freeze, manual indexes and ignored requests are each checked one cycle past the due edge.

// File: rtl/bias_pkg.sv
package bias_pkg;
    localparam int NCH   = 2;
    localparam int POS_W = 8;
    localparam int SUM_W = POS_W + 2;
    localparam int STEPS = 2 * NCH;

    typedef logic [POS_W-1:0]        pos_t;
    typedef logic signed [POS_W-1:0] ofs_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef enum logic [1:0] {
        SEL_BASE0 = 2'd0,
        SEL_BASE1 = 2'd1,
        SEL_OFS0  = 2'd2,
        SEL_OFS1  = 2'd3
    } tsel_e;

    typedef struct packed {
        pos_t base;
        ofs_t ofs;
    } chan_pair_t;

    // Step order is base0, ofs0, base1, ofs1: the select is the step with its bits swapped.
    function automatic tsel_e step_sel(logic [1:0] st);
        return tsel_e'({st[0], st[1]});
    endfunction

    function automatic sum_t widen_sum(pos_t b, ofs_t o);
        sum_t bw;
        sum_t ow;
        bw = sum_t'({2'b00, b});
        ow = sum_t'({{2{o[POS_W-1]}}, o});
        return bw + ow;
    endfunction

    function automatic pos_t clamp_pos(sum_t s);
        if (s < 0)
            return '0;
        else if (s > sum_t'(255))
            return '1;
        else
            return s[POS_W-1:0];
    endfunction
endpackage

// File: rtl/bias_idx_latch.sv
module bias_idx_latch
    import bias_pkg::*;
#(
    parameter int TIDX_W = 7,
    parameter int DIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              manual_en,
    input  logic [TIDX_W-1:0] mon_tidx,
    input  logic [DIDX_W-1:0] mon_didx [NCH],
    input  logic [TIDX_W-1:0] man_tidx,
    input  logic [DIDX_W-1:0] man_didx [NCH],
    output logic [TIDX_W-1:0] tidx_q,
    output logic [DIDX_W-1:0] didx_q [NCH]
);
    always_ff @(posedge clk) begin
        if (rst)
            tidx_q <= '0;
        else if (load)
            tidx_q <= manual_en ? man_tidx : mon_tidx;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_didx
        always_ff @(posedge clk) begin
            if (rst)
                didx_q[c] <= '0;
            else if (load)
                didx_q[c] <= manual_en ? man_didx[c] : mon_didx[c];
        end
    end
endmodule

// File: rtl/bias_rd_seq.sv
module bias_rd_seq
    import bias_pkg::*;
#(
    parameter int TIDX_W = 7,
    parameter int DIDX_W = 6,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              round_start,
    input  logic              freeze_en,
    input  logic [TIDX_W-1:0] tidx,
    input  logic [DIDX_W-1:0] didx [NCH],
    output logic              accept,
    output logic              rd_en,
    output logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [POS_W-1:0]  rd_data,
    output chan_pair_t        pair [NCH],
    output logic              load_now
);
    localparam int CNT_W    = 3;
    localparam int LAST_CNT = STEPS + 1;

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             rd_q;
    tsel_e            sel_q;
    tsel_e            sel_now;

    assign accept   = round_start && !freeze_en && !busy;
    assign rd_en    = busy && (cnt < CNT_W'(STEPS));
    assign sel_now  = step_sel(cnt[1:0]);
    assign rd_sel   = sel_now;
    assign load_now = busy && (cnt == CNT_W'(LAST_CNT));

    always_comb begin
        case (sel_now)
            SEL_OFS0: rd_addr = ADDR_W'(didx[0]);
            SEL_OFS1: rd_addr = ADDR_W'(didx[1]);
            default:  rd_addr = ADDR_W'(tidx);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
            if (load_now)
                busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            sel_q <= SEL_BASE0;
        end else begin
            rd_q  <= rd_en;
            sel_q <= sel_now;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst) begin
                pair[c] <= '0;
            end else if (rd_q) begin
                if (sel_q == tsel_e'(c))
                    pair[c].base <= rd_data;
                else if (sel_q == tsel_e'(c + NCH))
                    pair[c].ofs <= ofs_t'(rd_data);
            end
        end
    end

    AST_FROZEN_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (round_start && freeze_en && !busy) |=> !rd_en);                 // R8
    AST_LAST_READ_ENDS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd3) |=> !rd_en);                           // R6
    AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> (rd_en && rd_sel == 2'd0));                           // R6
endmodule

// File: rtl/bias_sat_add.sv
module bias_sat_add
    import bias_pkg::*;
(
    input  chan_pair_t pair [NCH],
    output pos_t       pos  [NCH]
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sum_t raw;
        assign raw    = widen_sum(pair[c].base, pair[c].ofs);
        assign pos[c] = clamp_pos(raw);
    end
endmodule

// File: rtl/bias_combiner.sv
module bias_combiner
    import bias_pkg::*;
#(
    parameter int TIDX_W = 7,
    parameter int DIDX_W = 6,
    localparam int ADDR_W = (TIDX_W > DIDX_W) ? TIDX_W : DIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              round_start,
    input  logic              freeze_en,
    input  logic              manual_en,
    input  logic [TIDX_W-1:0] mon_tidx,
    input  logic [DIDX_W-1:0] mon_didx0,
    input  logic [DIDX_W-1:0] mon_didx1,
    input  logic [TIDX_W-1:0] man_tidx,
    input  logic [DIDX_W-1:0] man_didx0,
    input  logic [DIDX_W-1:0] man_didx1,
    output logic              rd_en,
    output logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic [7:0]        wiper0,
    output logic [7:0]        wiper1,
    output logic              upd_done
);
    logic [DIDX_W-1:0] mon_d [NCH];
    logic [DIDX_W-1:0] man_d [NCH];
    logic [DIDX_W-1:0] didx_q [NCH];
    logic [TIDX_W-1:0] tidx_q;
    logic              accept;
    logic              load_now;
    chan_pair_t        pair [NCH];
    pos_t              sat_pos [NCH];
    pos_t              wiper_q [NCH];

    assign mon_d[0] = mon_didx0;
    assign mon_d[1] = mon_didx1;
    assign man_d[0] = man_didx0;
    assign man_d[1] = man_didx1;

    bias_idx_latch #(.TIDX_W(TIDX_W), .DIDX_W(DIDX_W)) u_idx (
        .clk(clk), .rst(rst), .load(accept), .manual_en(manual_en),
        .mon_tidx(mon_tidx), .mon_didx(mon_d),
        .man_tidx(man_tidx), .man_didx(man_d),
        .tidx_q(tidx_q), .didx_q(didx_q)
    );

    bias_rd_seq #(.TIDX_W(TIDX_W), .DIDX_W(DIDX_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .round_start(round_start), .freeze_en(freeze_en),
        .tidx(tidx_q), .didx(didx_q), .accept(accept),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .pair(pair), .load_now(load_now)
    );

    bias_sat_add u_sat (
        .pair(pair), .pos(sat_pos)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_wiper
        always_ff @(posedge clk) begin
            if (rst)
                wiper_q[c] <= '0;
            else if (load_now)
                wiper_q[c] <= sat_pos[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            upd_done <= 1'b0;
        else
            upd_done <= load_now;
    end

    assign wiper0 = wiper_q[0];
    assign wiper1 = wiper_q[1];

    AST_HOLD_W0: assert property (@(posedge clk) disable iff (rst)
        !upd_done |-> $stable(wiper0));                                  // R7
    AST_HOLD_W1: assert property (@(posedge clk) disable iff (rst)
        !upd_done |-> $stable(wiper1));                                  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        upd_done |=> !upd_done);                                         // R7
    AST_CLAMP_HI: assert property (@(posedge clk) disable iff (rst)
        (upd_done && !pair[0].ofs[7]) |-> (wiper0 >= pair[0].base));     // R3
    AST_CLAMP_LO: assert property (@(posedge clk) disable iff (rst)
        (upd_done && pair[0].ofs[7]) |-> (wiper0 <= pair[0].base));      // R4
endmodule

// File: tb/test_bias_combiner.sv
module test_bias_combiner;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       round_start = 1'b0;
    logic       freeze_en = 1'b0;
    logic       manual_en = 1'b0;
    logic [6:0] mon_tidx = '0;
    logic [5:0] mon_didx0 = '0;
    logic [5:0] mon_didx1 = '0;
    logic [6:0] man_tidx = '0;
    logic [5:0] man_didx0 = '0;
    logic [5:0] man_didx1 = '0;
    logic       rd_en;
    logic [1:0] rd_sel;
    logic [6:0] rd_addr;
    logic [7:0] rd_data = '0;
    logic [7:0] wiper0;
    logic [7:0] wiper1;
    logic       upd_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] tmem [2][128];
    logic [7:0] dmem [2][64];

    bias_combiner i_bias_combiner (
        .clk(clk), .rst(rst), .round_start(round_start), .freeze_en(freeze_en),
        .manual_en(manual_en), .mon_tidx(mon_tidx), .mon_didx0(mon_didx0),
        .mon_didx1(mon_didx1), .man_tidx(man_tidx), .man_didx0(man_didx0),
        .man_didx1(man_didx1), .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .rd_data(rd_data), .wiper0(wiper0), .wiper1(wiper1), .upd_done(upd_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Table memory with one cycle of read latency.
    always @(posedge clk) begin
        if (rd_en) begin
            case (rd_sel)
                2'd0: rd_data <= tmem[0][rd_addr];
                2'd1: rd_data <= tmem[1][rd_addr];
                2'd2: rd_data <= dmem[0][rd_addr[5:0]];
                default: rd_data <= dmem[1][rd_addr[5:0]];
            endcase
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int sat(int b, logic [7:0] d);
        int s;
        s = b + int'($signed(d));
        if (s > 255) return 255;
        if (s < 0) return 0;
        return s;
    endfunction

    // Behavioural reference model.
    bit busy_m = 0;
    int cnt_m = 0;
    int m_t = 0;
    int m_d0 = 0;
    int m_d1 = 0;
    int exp_w0 = 0;
    int exp_w1 = 0;
    bit exp_done = 0;
    int reads_m = 0;

    always @(posedge clk) begin
        if (rst) begin
            busy_m = 0; cnt_m = 0; exp_w0 = 0; exp_w1 = 0; exp_done = 0;
        end else begin
            exp_done = 0;
            if (busy_m) begin
                cnt_m++;
                if (cnt_m == 6) begin
                    exp_w0 = sat(int'(tmem[0][m_t]), dmem[0][m_d0]);
                    exp_w1 = sat(int'(tmem[1][m_t]), dmem[1][m_d1]);
                    exp_done = 1;
                    busy_m = 0;
                end
            end else if (round_start && !freeze_en) begin
                busy_m = 1; cnt_m = 0;
                m_t  = manual_en ? int'(man_tidx)  : int'(mon_tidx);
                m_d0 = manual_en ? int'(man_didx0) : int'(mon_didx0);
                m_d1 = manual_en ? int'(man_didx1) : int'(mon_didx1);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 wiper0 timing", int'(wiper0), exp_w0);
            chk("R7 wiper1 timing", int'(wiper1), exp_w1);
            chk("R7 upd_done", int'(upd_done), int'(exp_done));
            if (busy_m && cnt_m < 4) begin
                int es;
                int ea;
                es = (cnt_m == 0) ? 0 : (cnt_m == 1) ? 2 : (cnt_m == 2) ? 1 : 3;
                ea = (es == 2) ? m_d0 : (es == 3) ? m_d1 : m_t;
                chk("R6 rd_en", int'(rd_en), 1);
                chk("R5 rd_sel order", int'(rd_sel), es);
                chk("R5 rd_addr", int'(rd_addr), ea);
            end else begin
                chk("R6 R8 rd_en idle", int'(rd_en), 0);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        round_start = 1'b1;
        @(negedge clk);
        round_start = 1'b0;
    endtask

    task automatic wait_round();
        repeat (7) @(negedge clk);
    endtask

    task automatic set_mon(int t, int d0, int d1);
        mon_tidx = 7'(t); mon_didx0 = 6'(d0); mon_didx1 = 6'(d1);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 128; i++) tmem[c][i] = 8'd0;
            for (int i = 0; i < 64; i++) dmem[c][i] = 8'd0;
        end
        repeat (3) @(negedge clk);
        chk("R1 wiper0 reset", int'(wiper0), 0);
        chk("R1 wiper1 reset", int'(wiper1), 0);
        chk("R1 rd_en reset", int'(rd_en), 0);
        chk("R1 upd_done reset", int'(upd_done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 wiper0 after reset", int'(wiper0), 0);
        chk("R1 upd_done after reset", int'(upd_done), 0);

        // R2 in range, R3 above range
        tmem[0][10] = 8'd100; dmem[0][5] = 8'hEC;  // -20
        tmem[1][10] = 8'd200; dmem[1][7] = 8'd100;
        set_mon(10, 5, 7);
        pulse_start(); wait_round();
        chk("R2 in-range sum", int'(wiper0), 80);
        chk("R3 clamp high", int'(wiper1), 255);

        // R4 below range, R3 exact 255 and top 382
        tmem[0][11] = 8'd10;  dmem[0][6] = 8'hCE;  // -50
        tmem[1][11] = 8'd128; dmem[1][8] = 8'd127;
        set_mon(11, 6, 8);
        pulse_start(); wait_round();
        chk("R4 clamp low", int'(wiper0), 0);
        chk("R3 exact 255", int'(wiper1), 255);
        tmem[0][12] = 8'd255; dmem[0][9] = 8'd127;
        tmem[1][12] = 8'd0;   dmem[1][9] = 8'h80;  // -128
        set_mon(12, 9, 9);
        pulse_start(); wait_round();
        chk("R3 sum 382", int'(wiper0), 255);
        chk("R4 sum -128", int'(wiper1), 0);

        // R5 channel mapping
        tmem[0][20] = 8'd50; tmem[1][20] = 8'd150;
        dmem[0][3] = 8'd5;   dmem[1][3] = 8'hFB;   // -5
        set_mon(20, 3, 3);
        pulse_start(); wait_round();
        chk("R5 channel0 tables", int'(wiper0), 55);
        chk("R5 channel1 tables", int'(wiper1), 145);

        // R8 freeze
        tmem[0][30] = 8'd7; tmem[1][30] = 8'd9;
        set_mon(30, 0, 0);
        freeze_en = 1'b1;
        pulse_start(); wait_round(); wait_round();
        chk("R8 frozen wiper0", int'(wiper0), 55);
        chk("R8 frozen wiper1", int'(wiper1), 145);
        chk("R8 no done", int'(upd_done), 0);
        freeze_en = 1'b0;

        // R9 manual indexes
        tmem[0][40] = 8'd60; tmem[1][40] = 8'd70;
        dmem[0][11] = 8'd1;  dmem[1][12] = 8'd2;
        man_tidx = 7'd40; man_didx0 = 6'd11; man_didx1 = 6'd12;
        set_mon(30, 0, 0);
        manual_en = 1'b1;
        pulse_start(); wait_round();
        chk("R9 manual ch0", int'(wiper0), 61);
        chk("R9 manual ch1", int'(wiper1), 72);
        manual_en = 1'b0;

        // R10 second request while busy, R11 index change during round
        tmem[0][50] = 8'd33; tmem[1][50] = 8'd44;
        set_mon(50, 0, 0);
        pulse_start();
        set_mon(30, 0, 0);
        @(negedge clk);
        round_start = 1'b1;
        @(negedge clk);
        round_start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 R11 first round ch0", int'(wiper0), 33);
        chk("R10 R11 first round ch1", int'(wiper1), 44);
        wait_round();
        chk("R10 no second update", int'(wiper0), 33);

        // Random rounds checked by the model on every clock.
        for (int n = 0; n < 60; n++) begin
            for (int k = 0; k < 6; k++) begin
                tmem[k % 2][$urandom_range(0, 71)] = 8'($urandom);
                dmem[k % 2][$urandom_range(0, 63)] = 8'($urandom);
            end
            set_mon($urandom_range(0, 71), $urandom_range(0, 63), $urandom_range(0, 63));
            man_tidx = 7'($urandom_range(0, 71));
            man_didx0 = 6'($urandom); man_didx1 = 6'($urandom);
            manual_en = 1'($urandom);
            freeze_en = ($urandom_range(0, 3) == 0);
            pulse_start(); wait_round();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule